// File: doc/BRIEF.md
# Correctable Nanosecond Time Counter

This block keeps a free-running nanosecond count, clocked from a fixed reference. While running it adds a programmable step to the count on every clock. Frequency is trimmed by a second step value. A correction timer counts running clocks, and each time it fires the count advances by the correction step in place of the normal step. A correction step below the normal step slows the time base. A step above it speeds the time base up, and a correction step of twice the normal step applied on every clock runs the count at double rate.

Software reaches the block through a single-cycle register write port and a combinational read port. The register set holds a control word, the time value, a wrap period, a correction period and the two steps. Software can restart the count at zero, load a new time directly, and latch the live count into a capture register so that it reads a coherent value. With wrap enabled the count folds back at the programmed period. The carry past the period is kept, so a period of 0x80000000 gives a 31-bit nanosecond counter that loses no time.

A two-state machine (STOP, RUN) gates counting. The transition START (STOP to RUN) happens when the control word is written with the run bit set. The transition HALT (RUN to STOP) happens when the control word is written with it clear.

Top module: `tsc_timebase`

## Requirements
- R1: After reset, every register reads 0, `ns_now` is 0 and the machine is in STOP.
- R2: The count changes only on clocks where the machine is in RUN (control bit 0 written 1). In STOP it holds its value.
- R3: The step register (address 4) holds the normal step in bits 6:0 and the correction step in bits 14:8. Each running clock adds the correction step when the correction timer fires, and the normal step otherwise.
- R4: The correction period register (address 3) holds P. If P is 0 or 1, the correction fires on every running clock. If P is 2 or more, it fires on every (P+1)-th running clock, counted from reset or restart. While P is 0 the correction timer is held at zero.
- R5: When control bits 5:4 are both 1 and the sum of the count and the step reaches or exceeds the period register (address 2), the period is subtracted from that sum. Any other value of bits 5:4 disables the wrap.
- R6: Writing control bit 9 as 1 clears the count and the correction timer at that edge, ahead of any increment. The bit is self-clearing and reads back 0.
- R7: Writing control bit 11 as 1 latches the count present in the write cycle into the capture register. The captured value reads at address 1 from the next cycle and holds until the next capture. Bit 11 reads back 0.
- R8: A write to address 1 loads the count with the written data masked to its low 31 bits at that edge. The load takes priority over the increment.
- R9: Addresses are 0 control, 1 time, 2 period, 3 correction period and 4 step. Control reads back bit 0 (run) and bits 5:4 (wrap). Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ns_now | output | 32 | Live nanosecond count |

## Verification
The bound checker watches on every cycle that the count holds in STOP, that each running step without wrap equals one of the two programmed steps, and that a wrapped count stays below its period. It also checks that restart clears the count, that a time write lands masked, and that a capture holds the count seen in its request cycle. Which clocks receive the correction step, how the carry carries past a wrap, and the cumulative count over long runs can only be shown by the bench. The bench runs programmed step, correction and period combinations over known cycle counts and compares captured totals.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef logic [2:0] reg_addr_t;

    localparam reg_addr_t A_CTRL   = 3'd0;
    localparam reg_addr_t A_TIME   = 3'd1;
    localparam reg_addr_t A_PERIOD = 3'd2;
    localparam reg_addr_t A_CPER   = 3'd3;
    localparam reg_addr_t A_STEP   = 3'd4;

    localparam int CTL_RUN       = 0;
    localparam int CTL_WRAP_LO   = 4;
    localparam int CTL_WRAP_HI   = 5;
    localparam int CTL_RESTART   = 9;
    localparam int CTL_CAPTURE   = 11;
    localparam int STEP_CORR_LSB = 8;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/tsc_regs.sv
module tsc_regs
    import tsc_pkg::*;
#(
    parameter int W      = 32,
    parameter int STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      cap_val,
    output logic [W-1:0]      rdata,
    output logic              run,
    output logic              wrap_on,
    output logic [W-1:0]      period_q,
    output logic [W-1:0]      cper_q,
    output logic [STEP_W-1:0] norm_q,
    output logic [STEP_W-1:0] corr_q,
    output logic              restart_p,
    output logic              capture_p,
    output logic              load_p,
    output logic [W-1:0]      load_val
);

    run_state_e state_q, state_d;
    logic [1:0] wrap_q;
    logic       ctrl_wr;

    assign ctrl_wr   = wr && (addr == A_CTRL);
    assign restart_p = ctrl_wr && wdata[CTL_RESTART];
    assign capture_p = ctrl_wr && wdata[CTL_CAPTURE];
    assign load_p    = wr && (addr == A_TIME);
    assign load_val  = wdata;
    assign wrap_on   = (wrap_q == 2'b11);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // transitions START and HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (ctrl_wr && wdata[CTL_RUN])  state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr && !wdata[CTL_RUN]) state_d = ST_STOP;
            default: state_d = ST_STOP;
        endcase
    end

    // state outputs
    always_comb begin
        run = (state_q == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrap_q   <= '0;
            period_q <= '0;
            cper_q   <= '0;
            norm_q   <= '0;
            corr_q   <= '0;
        end else if (wr) begin
            unique case (addr)
                A_CTRL:   wrap_q   <= wdata[CTL_WRAP_HI:CTL_WRAP_LO];
                A_PERIOD: period_q <= wdata;
                A_CPER:   cper_q   <= wdata;
                A_STEP: begin
                    norm_q <= wdata[STEP_W-1:0];
                    corr_q <= wdata[STEP_CORR_LSB +: STEP_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[CTL_RUN]                 = run;
                rdata[CTL_WRAP_HI:CTL_WRAP_LO] = wrap_q;
            end
            A_TIME:   rdata = cap_val;
            A_PERIOD: rdata = period_q;
            A_CPER:   rdata = cper_q;
            A_STEP: begin
                rdata[STEP_W-1:0]              = norm_q;
                rdata[STEP_CORR_LSB +: STEP_W] = corr_q;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/tsc_corr_timer.sv
module tsc_corr_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         clear,
    input  logic [W-1:0] cper,
    output logic         fire
);

    logic [W-1:0] cnt_q;
    logic         every_clk;

    assign every_clk = (cper <= W'(1));
    assign fire      = every_clk || (cnt_q >= cper);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (clear)             cnt_q <= '0;
        else if (cper == '0)        cnt_q <= '0;
        else if (advance) begin
            if (fire) cnt_q <= '0;
            else      cnt_q <= cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/tsc_accum.sv
module tsc_accum #(
    parameter int W        = 32,
    parameter int STEP_W   = 7,
    parameter int ACTIVE_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              fire,
    input  logic [STEP_W-1:0] norm,
    input  logic [STEP_W-1:0] corr,
    input  logic              wrap_on,
    input  logic [W-1:0]      period,
    input  logic              restart,
    input  logic              load,
    input  logic [W-1:0]      load_val,
    input  logic              capture,
    output logic [W-1:0]      cnt,
    output logic [W-1:0]      cap
);

    localparam logic [W:0]   ONE_EXT = 1;
    localparam logic [W-1:0] MASK    = W'((ONE_EXT << ACTIVE_W) - ONE_EXT);

    logic [W-1:0]      cnt_q, cap_q, step_w, nxt, load_m;
    logic [STEP_W-1:0] step;
    logic [W:0]        sum;
    logic              wrap_hit;

    generate
        if (ACTIVE_W < W) begin : g_mask
            assign load_m = load_val & MASK;
        end else begin : g_full
            assign load_m = load_val;
        end
    endgenerate

    assign step     = fire ? corr : norm;
    assign step_w   = {{(W-STEP_W){1'b0}}, step};
    assign sum      = {1'b0, cnt_q} + {1'b0, step_w};
    assign wrap_hit = wrap_on && (sum >= {1'b0, period});
    assign nxt      = cnt_q + step_w - (wrap_hit ? period : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (load)    cnt_q <= load_m;
        else if (advance) cnt_q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cap_q <= '0;
        else if (capture) cap_q <= cnt_q;
    end

    assign cnt = cnt_q;
    assign cap = cap_q;

endmodule

// File: rtl/tsc_timebase.sv
module tsc_timebase #(
    parameter int W        = 32,
    parameter int STEP_W   = 7,
    parameter int ACTIVE_W = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [2:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    output logic [W-1:0] ns_now
);

    logic              run_w, wrap_on_w, restart_w, capture_w, load_w, fire_w;
    logic [W-1:0]      period_w, cper_w, load_val_w, cap_w, cnt_w;
    logic [STEP_W-1:0] norm_w, corr_w;

    tsc_regs #(.W(W), .STEP_W(STEP_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .cap_val   (cap_w),
        .rdata     (reg_rdata),
        .run       (run_w),
        .wrap_on   (wrap_on_w),
        .period_q  (period_w),
        .cper_q    (cper_w),
        .norm_q    (norm_w),
        .corr_q    (corr_w),
        .restart_p (restart_w),
        .capture_p (capture_w),
        .load_p    (load_w),
        .load_val  (load_val_w)
    );

    tsc_corr_timer #(.W(W)) u_corr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (run_w),
        .clear   (restart_w),
        .cper    (cper_w),
        .fire    (fire_w)
    );

    tsc_accum #(.W(W), .STEP_W(STEP_W), .ACTIVE_W(ACTIVE_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (run_w),
        .fire     (fire_w),
        .norm     (norm_w),
        .corr     (corr_w),
        .wrap_on  (wrap_on_w),
        .period   (period_w),
        .restart  (restart_w),
        .load     (load_w),
        .load_val (load_val_w),
        .capture  (capture_w),
        .cnt      (cnt_w),
        .cap      (cap_w)
    );

    assign ns_now = cnt_w;

endmodule

// File: rtl/tsc_timebase_chk.sv
module tsc_timebase_chk #(
    parameter int W        = 32,
    parameter int STEP_W   = 7,
    parameter int ACTIVE_W = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [W-1:0]      reg_wdata,
    input logic [W-1:0]      ns_now,
    input logic              run,
    input logic              wrap_on,
    input logic [W-1:0]      period,
    input logic [STEP_W-1:0] norm,
    input logic [STEP_W-1:0] corr,
    input logic [W-1:0]      cap
);

    localparam logic [W:0]   ONE_EXT = 1;
    localparam logic [W-1:0] MASK    = W'((ONE_EXT << ACTIVE_W) - ONE_EXT);

    logic [W-1:0] norm_x, corr_x;
    assign norm_x = {{(W-STEP_W){1'b0}}, norm};
    assign corr_x = {{(W-STEP_W){1'b0}}, corr};

    p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reg_wr) |=> $stable(ns_now));

    p_step_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap_on && !reg_wr) |=>
        ((ns_now - $past(ns_now)) == $past(norm_x) ||
         (ns_now - $past(ns_now)) == $past(corr_x)));

    p_wrap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wrap_on && !reg_wr && ns_now < period &&
         norm_x < period && corr_x < period) |=> (ns_now < period));

    p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[9]) |=> (ns_now == '0));

    p_capture_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[11]) |=> (cap == $past(ns_now)));

    p_load_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1) |=> (ns_now == ($past(reg_wdata) & MASK)));

endmodule

bind tsc_timebase tsc_timebase_chk #(.W(W), .STEP_W(STEP_W), .ACTIVE_W(ACTIVE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ns_now    (ns_now),
    .run       (run_w),
    .wrap_on   (wrap_on_w),
    .period    (period_w),
    .norm      (norm_w),
    .corr      (corr_w),
    .cap       (cap_w)
);

// File: tb/sim_tsc_timebase.sv
`timescale 1ns/1ps
module sim_tsc_timebase;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, ns_now;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tsc_timebase u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ns_now(ns_now)
    );

    typedef struct packed {
        logic [31:0] v;
        logic [6:0]  norm;
        logic [6:0]  corr;
        logic [31:0] cper;
        logic [31:0] period;
        logic        wrap;
        logic [15:0] n;
        logic [31:0] expv;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'd0,          7'd8,  7'd8,  32'd0, 32'd0,          1'b0, 16'd10, 32'd80},
        '{32'd100,        7'd8,  7'd9,  32'd3, 32'd0,          1'b0, 16'd10, 32'd182},
        '{32'd1000,       7'd8,  7'd7,  32'd4, 32'd0,          1'b0, 16'd20, 32'd1156},
        '{32'd0,          7'd8,  7'd16, 32'd0, 32'd0,          1'b0, 16'd10, 32'd160},
        '{32'd0,          7'd5,  7'd6,  32'd1, 32'd0,          1'b0, 16'd7,  32'd42},
        '{32'd90,         7'd8,  7'd8,  32'd0, 32'd100,        1'b1, 16'd5,  32'd30},
        '{32'h7FFF_FFF0,  7'd10, 7'd10, 32'd0, 32'h8000_0000,  1'b1, 16'd3,  32'd14},
        '{32'd45,         7'd4,  7'd6,  32'd2, 32'd50,         1'b1, 16'd6,  32'd23}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] expv);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, expv);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 ns_now", ns_now, 32'd0);
        for (int a = 0; a < 5; a++) begin
            rreg(3'(a), d);
            chk("R1 register", d, 32'd0);
        end

        // R9 / R6 / R7 control readback, self-clearing bits
        wreg(3'd0, 32'h0000_0A31);
        rreg(3'd0, d);
        chk("R9 R6 R7 ctrl readback", d, 32'h0000_0031);
        rreg(3'd5, d);
        chk("R9 unused address", d, 32'd0);

        // R8 load masking, R2 hold while stopped
        wreg(3'd0, 32'h0000_0200);
        wreg(3'd1, 32'hFFFF_FFFF);
        chk("R8 load mask", ns_now, 32'h7FFF_FFFF);
        idle(5);
        chk("R2 hold in STOP", ns_now, 32'h7FFF_FFFF);
        wreg(3'd0, 32'h0000_0800);
        rreg(3'd1, d);
        chk("R7 capture while stopped", d, 32'h7FFF_FFFF);

        // R5 single wrap bit does not enable wrap
        wreg(3'd0, 32'h0000_0200);
        wreg(3'd4, 32'h0000_0A0A);
        wreg(3'd3, 32'd0);
        wreg(3'd2, 32'd20);
        wreg(3'd0, 32'h0000_0011);
        idle(5);
        wreg(3'd0, 32'h0000_0811);
        rreg(3'd1, d);
        chk("R5 partial wrap field", d, 32'd50);
        chk("R2 running advance", ns_now, 32'd60);

        // R6 restart priority over increment
        wreg(3'd0, 32'h0000_0201);
        chk("R6 restart to zero", ns_now, 32'd0);
        idle(1);
        chk("R6 step after restart", ns_now, 32'd10);

        // R6 / R4 restart clears correction timer
        wreg(3'd4, 32'h0000_0504);
        wreg(3'd3, 32'd3);
        wreg(3'd0, 32'h0000_0201);
        idle(4);
        chk("R6 R4 correction timer cleared", ns_now, 32'd17);

        // R8 load over increment while running
        wreg(3'd1, 32'd1000);
        chk("R8 load priority", ns_now, 32'd1000);
        idle(1);
        chk("R3 step after load", ns_now, 32'd1004);

        // R7 capture coherence
        v = ns_now;
        wreg(3'd0, 32'h0000_0801);
        idle(3);
        rreg(3'd1, d);
        chk("R7 captured value", d, v);
        idle(2);
        rreg(3'd1, d);
        chk("R7 capture held", d, v);

        // R3 R4 R5 vector table
        for (int i = 0; i < NV; i++) begin
            logic [31:0] ctl;
            ctl = VECS[i].wrap ? 32'h0000_0031 : 32'h0000_0001;
            wreg(3'd0, 32'h0000_0200);
            wreg(3'd1, VECS[i].v);
            wreg(3'd4, {17'd0, VECS[i].corr, 1'b0, VECS[i].norm});
            wreg(3'd3, VECS[i].cper);
            wreg(3'd2, VECS[i].period);
            wreg(3'd0, ctl);
            idle(int'(VECS[i].n));
            wreg(3'd0, ctl | 32'h0000_0800);
            rreg(3'd1, d);
            chk($sformatf("R3 R4 R5 vector %0d", i), d, VECS[i].expv);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule